// File: doc/BRIEF.md
# DMA Request Source Multiplexer

This block sits between a set of DMA request sources and the request inputs of a DMA engine. Up to 64 source lines come in, drawn from peripherals or from permanently asserted slots. Each of `NUM_CH` output channels picks one of these lines. A per-channel byte of configuration decides whether that channel is off, forwards its chosen source unchanged, or forwards it only after a periodic trigger has armed it.

The configuration bytes are reached through a small memory-mapped bus. That bus accepts byte, halfword and word transfers. It checks the alignment of each access, and it packs up to four channel bytes into the 32-bit data path. Each access gets exactly one response, one cycle later, which carries the read data or an error flag.

Each channel holds an arm state machine with two states. `ARM_IDLE` waits for a trigger edge. `ARM_SET` forwards the source. The transition `IDLE→SET` happens on a trigger rising edge while the channel is in trigger mode. The transition `SET→IDLE` happens on an acknowledged forwarded request, or when the channel leaves trigger mode. A new trigger edge while in `ARM_SET` keeps the channel armed.

Top module: `dmx_req_mux`

## Requirements
- R1: After reset every configuration byte is zero, every `chan_req` bit is low, and reads return zero.
- R2: Channel n owns the byte at offset n. Within that byte, bit 7 is the enable, bit 6 is the trigger enable, and bits 5:0 are the source index.
- R3: Lane packing works as follows. A word access at offset 4k carries channel 4k in data[31:24], channel 4k+1 in [23:16], channel 4k+2 in [15:8] and channel 4k+3 in [7:0]. A halfword or byte access uses only the lanes of the bytes it covers, and it reads zero in the other lanes. `bus_size` encodes 0 as byte, 1 as halfword and 2 as word.
- R4: The following accesses are illegal: a halfword at an odd offset, a word at an offset that is not a multiple of four, and any access with `bus_size` equal to 3. An illegal access gives `rsp_err` high together with `rsp_valid` for one cycle and `rsp_rdata` of zero, and it changes no configuration byte.
- R5: `rsp_valid` is high in the cycle after each cycle with `bus_valid` high, and low otherwise. A write is visible from the following cycle.
- R6: When the enable bit is 0, `chan_req` of that channel is low whatever the trigger enable bit and the source hold.
- R7: With enable 1 and trigger enable 0, `chan_req` follows the selected source line in the same cycle.
- R8: With enable 1 and trigger enable 1, a rising edge on `chan_trig` arms the channel from the next cycle onward. While the channel is armed it forwards the selected source. An acknowledge received while a request is forwarded disarms the channel at the next edge.
- R9: Writing the enable bit to 0 clears any pending arm. Re-enabling trigger mode then needs a new trigger edge.
- R10: A trigger input that stays high without a new rising edge does not re-arm the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data, lane-packed |
| rsp_valid | output | 1 | Response strobe, one cycle after access |
| rsp_err | output | 1 | Illegal access indication |
| rsp_rdata | output | 32 | Read data, lane-packed |
| src_req | input | NUM_SRC | Incoming DMA request lines |
| chan_trig | input | NUM_CH | Periodic trigger per channel |
| chan_ack | input | NUM_CH | DMA acknowledge per channel |
| chan_req | output | NUM_CH | Routed request per channel |

## Verification
The embedded assertions watch the following on every cycle. Each access gets exactly one response a cycle later. An illegal access leaves every configuration byte unchanged and answers with zero data. The arm state never leaves `ARM_IDLE` without a trigger edge. It returns to idle after an acknowledged forward and whenever the channel is not in trigger mode. The bench scenarios cover what a per-cycle property cannot settle: the lane placement of written and read bytes, the same-cycle routing of the selected source, and a full arm-forward-acknowledge-rearm sequence ending with a disable and re-enable that must not revive a stale arm.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // Configuration byte layout
    localparam int CFG_EN_BIT   = 7;
    localparam int CFG_TRIG_BIT = 6;
    localparam int SRC_W        = 6;
    localparam int SRC_SPACE    = 1 << SRC_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_PASS,
        MODE_TRIG
    } chan_mode_e;

    typedef enum logic {
        ARM_IDLE,
        ARM_SET
    } arm_state_e;

    function automatic chan_mode_e cfg_mode(logic [7:0] c);
        if (!c[CFG_EN_BIT])        return MODE_OFF;
        else if (!c[CFG_TRIG_BIT]) return MODE_PASS;
        else                       return MODE_TRIG;
    endfunction

endpackage

// File: rtl/dmx_regif.sv
module dmx_regif
    import dmx_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int AW     = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [1:0]          bus_size,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                rsp_valid_o,
    output logic                rsp_err_o,
    output logic [31:0]         rsp_rdata_o,
    output logic [NUM_CH*8-1:0] cfg_o
);

    logic          misal;
    logic [3:0]    be;
    logic [AW-3:0] widx;
    logic          wr_ok;
    logic [31:0]   rd_word;
    logic [AW-1:0] ridx;

    // Alignment check and byte-enable decode
    always_comb begin
        widx = bus_addr[AW-1:2];
        unique case (bus_size)
            SZ_BYTE: begin misal = 1'b0;           be = 4'b0001 << bus_addr[1:0];          end
            SZ_HALF: begin misal = bus_addr[0];    be = bus_addr[1] ? 4'b1100 : 4'b0011;   end
            SZ_WORD: begin misal = |bus_addr[1:0]; be = 4'b1111;                           end
            default: begin misal = 1'b1;           be = 4'b0000;                           end
        endcase
    end

    assign wr_ok = bus_valid && bus_write && !misal;

    // Lane j of a word holds channel 4*widx+j in bits [31-8j -: 8]
    always_comb begin
        rd_word = '0;
        ridx    = '0;
        for (int j = 0; j < 4; j++) begin
            ridx = {widx, 2'(j)};
            if (be[j]) rd_word[31-8*j -: 8] = cfg_o[ridx*8 +: 8];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        localparam int LANE = c % 4;
        localparam int WI   = c / 4;
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_ok && widx == (AW-2)'(WI) && be[LANE])
                q <= bus_wdata[31-8*LANE -: 8];
        end
        assign cfg_o[c*8 +: 8] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= bus_valid;
            rsp_err_o   <= bus_valid && misal;
            rsp_rdata_o <= (bus_valid && !bus_write && !misal) ? rd_word : '0;
        end
    end

    // R4: an illegal write leaves all configuration untouched
    a_r4_misal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && misal) |=> $stable(cfg_o));

    // R4: an error response is a valid response with zero data
    a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0));

    // R5: one response per access, one cycle later
    a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid_o);
    a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !rsp_valid_o);

    // R5: configuration only moves on a bus access
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> $stable(cfg_o));

endmodule

// File: rtl/dmx_chan_gate.sv
module dmx_chan_gate
    import dmx_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_i,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               trig_i,
    input  logic               ack_i,
    output logic               req_o
);

    arm_state_e           state_q, state_d;
    chan_mode_e           mode;
    logic                 trig_q;
    logic                 trig_edge;
    logic                 sel_req;
    logic [SRC_SPACE-1:0] src_pad;

    assign mode = cfg_mode(cfg_i);

    always_comb begin
        src_pad              = '0;
        src_pad[NUM_SRC-1:0] = src_req_i;
    end

    assign sel_req   = src_pad[cfg_i[SRC_W-1:0]];
    assign trig_edge = trig_i && !trig_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_i;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (mode == MODE_TRIG && trig_edge) state_d = ARM_SET;
            ARM_SET: begin
                if (mode != MODE_TRIG)      state_d = ARM_IDLE;
                else if (trig_edge)         state_d = ARM_SET;
                else if (req_o && ack_i)    state_d = ARM_IDLE;
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (mode)
            MODE_PASS: req_o = sel_req;
            MODE_TRIG: req_o = sel_req && (state_q == ARM_SET);
            default:   req_o = 1'b0;
        endcase
    end

    // R9: leaving trigger mode drops the arm
    a_r9_off_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TRIG) |=> (state_q == ARM_IDLE));

    // R8: acknowledged forward disarms
    a_r8_ack_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_SET && req_o && ack_i && !trig_edge) |=> (state_q == ARM_IDLE));

    // R10: no edge, no arm
    a_r10_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_IDLE && !trig_edge) |=> (state_q == ARM_IDLE));

    // R6: disabled channel never requests
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[CFG_EN_BIT] |-> !req_o);

endmodule

// File: rtl/dmx_req_mux.sv
module dmx_req_mux
    import dmx_pkg::*;
#(
    parameter  int NUM_CH  = 8,
    parameter  int NUM_SRC = 64,
    localparam int ADDR_W  = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_CH-1:0]  chan_trig,
    input  logic [NUM_CH-1:0]  chan_ack,
    output logic [NUM_CH-1:0]  chan_req
);

    logic [NUM_CH*8-1:0] cfg_flat;

    dmx_regif #(.NUM_CH(NUM_CH)) i_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_size    (bus_size),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .rsp_rdata_o (rsp_rdata),
        .cfg_o       (cfg_flat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dmx_chan_gate #(.NUM_SRC(NUM_SRC)) i_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (cfg_flat[c*8 +: 8]),
            .src_req_i (src_req),
            .trig_i    (chan_trig[c]),
            .ack_i     (chan_ack[c]),
            .req_o     (chan_req[c])
        );
    end

endmodule

// File: tb/test_dmx_req_mux.sv
module test_dmx_req_mux;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int NSRC = 64;

    typedef struct {
        logic        err;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [1:0]       bus_size = 2'd0;
    logic [2:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             rsp_valid, rsp_err;
    logic [31:0]      rsp_rdata;
    logic [NSRC-1:0]  src_req = '0;
    logic [NCH-1:0]   chan_trig = '0;
    logic [NCH-1:0]   chan_ack = '0;
    logic [NCH-1:0]   chan_req;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx_req_mux #(.NUM_CH(NCH), .NUM_SRC(NSRC)) i_dmx_req_mux (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .src_req(src_req), .chan_trig(chan_trig), .chan_ack(chan_ack), .chan_req(chan_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one access, expectation pushed to the scoreboard
    task automatic bus_op(input logic wr, input logic [1:0] sz, input logic [2:0] addr,
                          input logic [31:0] wd, input logic e_err, input logic [31:0] e_rd,
                          input string req);
        exp_t e;
        e.err = e_err; e.data = e_rd; e.req = req;
        exp_q.push_back(e);
        bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
        @(negedge clk);
    endtask

    // Monitor: compare each response against the queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
                check({e.req, " data"}, rsp_rdata, e.data);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        src_req = '1;
        #1 check("R1 reset chan_req", {24'd0, chan_req}, 32'd0);
        src_req = '0;
        bus_op(1'b0, 2'd2, 3'd0, '0, 1'b0, 32'h0, "R1 read word0");
        bus_op(1'b0, 2'd2, 3'd4, '0, 1'b0, 32'h0, "R1 read word4");

        // R2 R3: word write then read back
        bus_op(1'b1, 2'd2, 3'd0, 32'h80C1_0243, 1'b0, 32'h0, "R2 write word0");
        bus_op(1'b0, 2'd2, 3'd0, '0, 1'b0, 32'h80C1_0243, "R2 read word0");
        // R3: byte write to offset 5 uses lane [23:16]
        bus_op(1'b1, 2'd0, 3'd5, 32'h0085_0000, 1'b0, 32'h0, "R3 write byte5");
        bus_op(1'b0, 2'd1, 3'd4, '0, 1'b0, 32'h0085_0000, "R3 read half4");
        bus_op(1'b0, 2'd0, 3'd5, '0, 1'b0, 32'h0085_0000, "R3 read byte5");
        // R3: halfword write to offset 6 uses lanes [15:0]
        bus_op(1'b1, 2'd1, 3'd6, 32'hFFFF_8A07, 1'b0, 32'h0, "R3 write half6");
        bus_op(1'b0, 2'd2, 3'd4, '0, 1'b0, 32'h0085_8A07, "R3 read word4");

        // R4: illegal accesses
        bus_op(1'b1, 2'd1, 3'd1, 32'hFFFF_FFFF, 1'b1, 32'h0, "R4 misaligned half write");
        bus_op(1'b0, 2'd2, 3'd2, '0, 1'b1, 32'h0, "R4 misaligned word read");
        bus_op(1'b1, 2'd3, 3'd0, 32'hFFFF_FFFF, 1'b1, 32'h0, "R4 size3 write");
        bus_op(1'b0, 2'd2, 3'd0, '0, 1'b0, 32'h80C1_0243, "R4 word0 unchanged");

        // R7: transparent channels follow the source in the same cycle
        src_req[0] = 1'b1;
        #1 check("R7 ch0 follows src0", {31'd0, chan_req[0]}, 32'd1);
        src_req[5] = 1'b1;
        #1 check("R7 ch5 follows src5", {31'd0, chan_req[5]}, 32'd1);
        src_req[0] = 1'b0;
        #1 check("R7 ch0 drops with src0", {31'd0, chan_req[0]}, 32'd0);
        // R6: disabled channels stay low
        src_req[2] = 1'b1; src_req[3] = 1'b1;
        #1 check("R6 ch2 disabled", {31'd0, chan_req[2]}, 32'd0);
        check("R6 ch3 trig set but disabled", {31'd0, chan_req[3]}, 32'd0);

        // R8: trigger mode on ch1 (source 1)
        @(negedge clk);
        src_req[1] = 1'b1;
        #1 check("R8 ch1 not armed", {31'd0, chan_req[1]}, 32'd0);
        @(negedge clk);
        chan_trig[1] = 1'b1;
        @(negedge clk);
        #1 check("R8 ch1 armed forwards", {31'd0, chan_req[1]}, 32'd1);
        chan_ack[1] = 1'b1;
        @(negedge clk);
        chan_ack[1] = 1'b0;
        #1 check("R8 ch1 disarmed by ack", {31'd0, chan_req[1]}, 32'd0);
        // R10: level-high trigger does not re-arm
        repeat (3) @(negedge clk);
        #1 check("R10 held trigger no rearm", {31'd0, chan_req[1]}, 32'd0);
        // R8: new edge re-arms
        chan_trig[1] = 1'b0;
        @(negedge clk);
        chan_trig[1] = 1'b1;
        @(negedge clk);
        #1 check("R8 ch1 rearmed", {31'd0, chan_req[1]}, 32'd1);

        // R9: disable clears the arm, re-enable needs a new edge
        bus_op(1'b1, 2'd0, 3'd1, 32'h0041_0000, 1'b0, 32'h0, "R9 disable ch1");
        #1 check("R6 ch1 disabled", {31'd0, chan_req[1]}, 32'd0);
        bus_op(1'b1, 2'd0, 3'd1, 32'h00C1_0000, 1'b0, 32'h0, "R9 reenable ch1");
        #1 check("R9 ch1 stale arm gone", {31'd0, chan_req[1]}, 32'd0);

        @(negedge clk);
        check("R5 all responses seen", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule